// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address sequence that a synchronous DRAM uses for one read or write burst. When a read or write command is accepted, the controller pulses a start strobe together with the 9-bit starting column, a burst length code and an order select. From the next clock on, the block presents one column per cycle, raises an active flag for the whole burst, and marks the final address of a fixed-length burst with a last-beat flag.

Two address orders are supported. Sequential order counts up within the group of columns aligned to the burst length and wraps inside that group. Interleaved order XORs the beat number into the low column bits. A full-page length with sequential order walks the whole 512-column row, wraps from 511 back to 0, and runs until it is stopped or replaced.

A burst can be cut short at any cycle by a stop strobe. A new start strobe on any cycle, including during a running burst, restarts the sequence from the new column with the new mode. Decoding the mode register and the storage array are handled elsewhere.

Top module: `burst_col_gen`

## Requirements
- R1: During and right after reset, `active` and `lastBeat` are 0 and `col` is 0.
- R2: A start strobe sampled at a clock edge makes `active` 1 and `col` equal to `startCol` after that edge; `lenCode` selects the length as 000=1, 001=2, 010=4, 011=8, and 1xx=full page.
- R3: In sequential order with length BL, beat i shows the upper column bits of `startCol` unchanged and the low log2(BL) bits equal to (low bits of `startCol` + i) mod BL.
- R4: In interleaved order (`interleave`=1) with length BL, beat i shows `startCol` with its low log2(BL) bits XORed with i.
- R5: A fixed-length burst keeps `active` high for exactly BL cycles, raises `lastBeat` only on its final beat, and returns to idle in the following cycle.
- R6: A full-page burst (length code 1xx, `interleave`=0) shows (`startCol` + i) mod 512 at beat i, wrapping from 511 to 0, never raises `lastBeat`, and runs until a stop or start strobe.
- R7: A length code of 1xx with `interleave`=1 is not a legal pairing; the block runs it as an interleaved burst of length 8.
- R8: A stop strobe without a start strobe during a burst makes `active` 0 from the next cycle on.
- R9: A start strobe during a burst restarts from the new column and mode at the next cycle; a start strobe wins over a stop strobe in the same cycle.
- R10: While idle, `col` is 0 and `lastBeat` is 0, and a stop strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| startStb | input | 1 | Accept a new burst this cycle |
| startCol | input | 9 | First column of the new burst |
| lenCode | input | 3 | Burst length select (000=1, 001=2, 010=4, 011=8, 1xx=full page) |
| interleave | input | 1 | 1 = interleaved order, 0 = sequential |
| stopStb | input | 1 | Terminate the running burst |
| col | output | 9 | Current column address, 0 when idle |
| active | output | 1 | A burst is presenting an address this cycle |
| lastBeat | output | 1 | Current address is the final one of a fixed-length burst |

## Verification
Directed bursts start from columns near the top of an aligned group, so that sequential wrap inside the group is told apart from a plain increment and from XOR order, and a full-page run crosses column 511 to 0 to tell row wrap from group wrap. The illegal interleaved full-page pairing, a stop in mid-burst, a restart in mid-burst, and coincident start and stop strobes are each driven on their own. A long run of random starts, stops, lengths and orders from a fixed seed then mixes restarts at every beat position against a bench model built from the requirements.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  localparam int LEN_CODE_W = 3;
  localparam int FIXED_MAX_LOG2 = 3;

  typedef struct packed {
    logic load;
    logic advance;
    logic busy;
  } colStrobes_t;

  // log2 of the burst length selected by a length code
  function automatic int unsigned burstLog2(input logic [LEN_CODE_W-1:0] code,
                                            input logic ilv,
                                            input int unsigned colW);
    if (code[LEN_CODE_W-1]) begin
      if (ilv) return FIXED_MAX_LOG2;
      return colW;
    end
    return int'(code[1:0]);
  endfunction

  function automatic logic isFullPage(input logic [LEN_CODE_W-1:0] code,
                                      input logic ilv);
    return code[LEN_CODE_W-1] & ~ilv;
  endfunction

endpackage

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startStb,
  input  logic                  stopStb,
  input  logic [LEN_CODE_W-1:0] lenCode,
  input  logic                  interleave,
  output colStrobes_t           stb,
  output logic                  active,
  output logic                  lastBeat
);

  logic             activeQ;
  logic             fullPageQ;
  logic [COL_W-1:0] beatsLeftQ;
  logic [COL_W-1:0] burstSpan;
  logic             atEnd;

  always_comb begin
    burstSpan = COL_W'((1 << burstLog2(lenCode, interleave, COL_W)) - 1);
  end

  assign atEnd = activeQ & ~fullPageQ & (beatsLeftQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ    <= 1'b0;
      fullPageQ  <= 1'b0;
      beatsLeftQ <= '0;
    end else if (startStb) begin
      activeQ    <= 1'b1;
      fullPageQ  <= isFullPage(lenCode, interleave);
      beatsLeftQ <= burstSpan;
    end else if (activeQ) begin
      if (stopStb || atEnd) begin
        activeQ <= 1'b0;
      end else if (!fullPageQ) begin
        beatsLeftQ <= beatsLeftQ - 1'b1;
      end
    end
  end

  always_comb begin
    stb.load    = startStb;
    stb.advance = activeQ & ~startStb & ~stopStb & ~atEnd;
    stb.busy    = activeQ;
  end

  assign active   = activeQ;
  assign lastBeat = atEnd;

endmodule

// File: rtl/burst_col_datapath.sv
module burst_col_datapath
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  colStrobes_t           stb,
  input  logic [COL_W-1:0]      startCol,
  input  logic [LEN_CODE_W-1:0] lenCode,
  input  logic                  interleave,
  output logic [COL_W-1:0]      col
);

  logic [COL_W-1:0] baseQ;
  logic [COL_W-1:0] offsetQ;
  logic [COL_W-1:0] maskQ;
  logic             ilvQ;
  logic [COL_W-1:0] maskNext;
  logic [COL_W-1:0] seqCol;
  logic [COL_W-1:0] ilvCol;
  logic [COL_W-1:0] sum;

  always_comb begin
    maskNext = COL_W'((1 << burstLog2(lenCode, interleave, COL_W)) - 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ   <= '0;
      offsetQ <= '0;
      maskQ   <= '0;
      ilvQ    <= 1'b0;
    end else if (stb.load) begin
      baseQ   <= startCol;
      offsetQ <= '0;
      maskQ   <= maskNext;
      ilvQ    <= interleave;
    end else if (stb.advance) begin
      offsetQ <= offsetQ + 1'b1;
    end
  end

  assign sum = baseQ + offsetQ;

  // per-bit select: masked bits follow the order, the rest hold the base
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign seqCol[b] = maskQ[b] ? sum[b] : baseQ[b];
    assign ilvCol[b] = maskQ[b] ? (baseQ[b] ^ offsetQ[b]) : baseQ[b];
  end

  assign col = stb.busy ? (ilvQ ? ilvCol : seqCol) : '0;

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startStb,
  input  logic [COL_W-1:0]      startCol,
  input  logic [LEN_CODE_W-1:0] lenCode,
  input  logic                  interleave,
  input  logic                  stopStb,
  output logic [COL_W-1:0]      col,
  output logic                  active,
  output logic                  lastBeat
);

  colStrobes_t stb;

  burst_col_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startStb(startStb), .stopStb(stopStb),
    .lenCode(lenCode), .interleave(interleave), .stb(stb),
    .active(active), .lastBeat(lastBeat)
  );

  burst_col_datapath #(.COL_W(COL_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .startCol(startCol),
    .lenCode(lenCode), .interleave(interleave), .col(col)
  );

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             startStb,
  input logic [COL_W-1:0] startCol,
  input logic             stopStb,
  input logic [COL_W-1:0] col,
  input logic             active,
  input logic             lastBeat
);

  // R2
  start_loads_chk: assert property (@(posedge clk) disable iff (!rstN)
    startStb |=> (active && col == $past(startCol)));

  // R8
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopStb && !startStb) |=> !active);

  // R5
  last_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && !startStb) |=> !active);

  // R5
  last_in_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> active);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> (col == '0 && !lastBeat));

  // R9
  start_over_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startStb && stopStb) |=> active);

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rstN(rstN), .startStb(startStb), .startCol(startCol),
  .stopStb(stopStb), .col(col), .active(active), .lastBeat(lastBeat)
);

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;

  localparam int COL_W = 9;
  localparam int PAGE = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startStb = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic [2:0]       lenCode = '0;
  logic             interleave = 1'b0;
  logic             stopStb = 1'b0;
  logic [COL_W-1:0] col;
  logic             active;
  logic             lastBeat;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  string curReq = "R1";

  // bench model state
  bit mAct = 0;
  bit mFp = 0;
  bit mIlv = 0;
  int mBase = 0;
  int mBeat = 0;
  int mLen = 1;

  always #2.5 clk = ~clk;

  burst_col_gen u_burst_col_gen (
    .clk(clk), .rstN(rstN), .startStb(startStb), .startCol(startCol),
    .lenCode(lenCode), .interleave(interleave), .stopStb(stopStb),
    .col(col), .active(active), .lastBeat(lastBeat)
  );

  function automatic int expCol();
    int m;
    if (!mAct) return 0;
    if (mFp) return (mBase + mBeat) % PAGE;
    m = mLen - 1;
    if (mIlv) return mBase ^ mBeat;
    return (mBase & ~m & (PAGE - 1)) | ((mBase + mBeat) & m);
  endfunction

  function automatic bit expLast();
    return mAct && !mFp && (mBeat == mLen - 1);
  endfunction

  task automatic compare();
    int ec = expCol();
    bit el = expLast();
    checks++;
    if (int'(col) != ec || active != mAct || lastBeat != el) begin
      fails++;
      $display("FAIL %s: col=%0h active=%0b last=%0b expected col=%0h active=%0b last=%0b",
               curReq, col, active, lastBeat, ec, mAct, el);
    end
  endtask

  // check current outputs at the negedge, then drive and advance the model
  task automatic step(input bit s, input int c, input int len, input bit il, input bit st);
    @(negedge clk);
    compare();
    startStb = s; startCol = COL_W'(c); lenCode = 3'(len); interleave = il; stopStb = st;
    if (s) begin
      mAct = 1; mBase = c; mBeat = 0; mIlv = il;
      mFp = len[2] && !il;
      mLen = len[2] ? (il ? 8 : PAGE) : (1 << len[1:0]);
    end else if (mAct) begin
      if (st || (!mFp && mBeat == mLen - 1)) mAct = 0;
      else mBeat = (mBeat + 1) % PAGE;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_c01));
    repeat (3) @(posedge clk);
    curReq = "R1";
    @(negedge clk); compare();
    rstN = 1'b1;
    idle(2);

    // R3: sequential length 8 from near group top wraps inside group
    curReq = "R3"; step(1, 9'h0FE, 3'b011, 0, 0); idle(9);
    curReq = "R3"; step(1, 9'h103, 3'b010, 0, 0); idle(5);
    // R2: length 1 and 2
    curReq = "R2"; step(1, 9'h155, 3'b000, 0, 0); idle(2);
    curReq = "R5"; step(1, 9'h0A1, 3'b001, 0, 0); idle(3);
    // R4: interleaved
    curReq = "R4"; step(1, 9'h0F5, 3'b011, 1, 0); idle(9);
    curReq = "R4"; step(1, 9'h1E2, 3'b010, 1, 0); idle(5);
    // R6: full page crossing 511 -> 0
    curReq = "R6"; step(1, 9'h1FC, 3'b111, 0, 0); idle(12);
    curReq = "R8"; step(0, 0, 0, 0, 1); idle(3);
    // R7: illegal interleaved full page runs as interleaved 8
    curReq = "R7"; step(1, 9'h005, 3'b100, 1, 0); idle(10);
    // R8: stop mid-burst
    curReq = "R8"; step(1, 9'h040, 3'b011, 0, 0); idle(2); step(0, 0, 0, 0, 1); idle(3);
    // R9: restart mid-burst, and start with stop together
    curReq = "R9"; step(1, 9'h010, 3'b011, 0, 0); idle(3);
    step(1, 9'h1F7, 3'b010, 1, 0); idle(1);
    step(1, 9'h0C3, 3'b001, 0, 1); idle(4);
    // R10: stop while idle
    curReq = "R10"; step(0, 0, 0, 0, 1); idle(2);

    // random mix
    curReq = "R2";
    for (int k = 0; k < 4000; k++) begin
      bit s = ($urandom % 8) == 0;
      bit st = ($urandom % 24) == 0;
      step(s, int'($urandom % PAGE), int'($urandom % 8), bit'($urandom % 2), st);
    end
    idle(2);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule